// File: doc/BRIEF.md
# Burst-to-PCI Transaction Splitter

This block sits inside a memory-mapped-to-PCI bridge, between a burst-capable slave port and the engine that drives the PCI bus as master. It takes one burst request at a time: a byte address, a beat count, a direction and a bus-width flag. From these and the cacheline size register it builds PCI transaction descriptors. Each descriptor holds a PCI command, a translated PCI address and a dword count.

The PCI command is chosen from the burst length and from how many cachelines the burst covers. A burst that runs past the end of an address-translation page is cut into two descriptors. Each piece gets its own translated address from a small page table, which is indexed by page number.

Reads are delayed transactions on PCI, so the block counts how many are outstanding. The mode input sets the cap at one or at four. Writes are posted. A status flag stays high while an accepted write still has a descriptor that has not been handed to the PCI engine.

Top module: `bts_splitter`

## Requirements
- R1: A request may start at any dword address. Address bits [1:0] are ignored and are always zero in the descriptor address.
- R2: A beat count of 0 is treated as 1, and a count above 128 is clamped to 128. The total dword count equals the beat count on the 32-bit bus (`req_wide`=0) and twice the beat count on the 64-bit bus (`req_wide`=1).
- R3: A burst whose last byte lies in a later 2^PAGE_W-byte page than its first byte is issued as exactly two descriptors, in this order. The first covers the dwords up to the page end. The second starts at offset 0 of the next page and carries the remaining dwords. Any other burst is issued as one descriptor.
- R4: A descriptor address keeps the page offset (the low PAGE_W bits). Its upper bits are replaced by the page-table entry selected by page number modulo PT_DEPTH. The second piece of a split uses the entry that follows the first piece's entry, wrapping at PT_DEPTH. `pt_wr` writes `pt_frame` into entry `pt_idx`. After reset, entry i holds the value i.
- R5: A read of more than one beat whose byte range touches more than one cacheline gets Memory Read Multiple, 4'b1100. The cacheline is `cls_dwords` dwords long, a power of two. A value of 0 means no cacheline, and the read is then never multi-line.
- R6: A read of more than one beat that stays within one cacheline gets Memory Read Line, 4'b1110. A one-beat read gets Memory Read, 4'b0110. Every write gets Memory Write, 4'b0111. Both pieces of a split carry the same command.
- R7: A read descriptor is offered only while fewer reads are outstanding than the cap: 1 when `multi_mode`=0 and 4 when `multi_mode`=1. `rd_outstanding` rises by one when a read descriptor is accepted and falls by one on a `rd_done` pulse, but never below zero.
- R8: `wip` is high from the cycle after a write request is accepted until its last descriptor has been accepted.
- R9: `req_ready` stays low while any descriptor of the current burst, including the second piece of a split, is still pending. A descriptor that is offered but not accepted keeps its command, address and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | ADDR_W | Byte address of the burst |
| req_beats | input | CNT_W | Beat count |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit beats, 0 = 32-bit beats |
| cls_dwords | input | CLS_W | Cacheline size in dwords |
| multi_mode | input | 1 | 1 = up to four outstanding reads, 0 = one |
| rd_done | input | 1 | One-cycle pulse: a delayed read completed |
| pt_wr | input | 1 | Page-table write strobe |
| pt_idx | input | IDX_W | Page-table entry to write |
| pt_frame | input | ADDR_W-PAGE_W | Upper address bits for that entry |
| desc_valid | output | 1 | Descriptor valid |
| desc_ready | input | 1 | Descriptor accepted when high together with valid |
| desc_cmd | output | 4 | PCI bus command |
| desc_addr | output | ADDR_W | Translated PCI byte address |
| desc_dwords | output | DW_W | Dword count of the transaction |
| wip | output | 1 | A posted write has not yet been fully issued |
| rd_outstanding | output | RD_W | Delayed reads in flight |

## Verification
Several properties are checked on every cycle:
- A request is never accepted while a descriptor is offered.
- An offered descriptor stays stable until it is accepted.
- Descriptor addresses are dword aligned and dword counts are nonzero and within the clamp.
- A read is never offered at or above the mode's cap.
- A write is flagged as in progress and carries the write command.

Only the bench scenarios can show the content of each descriptor against an independent model. That covers the command choice on both sides of a cacheline boundary, the split point and the remainder at page ends, including a wrap to page-table entry 0. It also covers translation after page-table writes, and the stall of a second read in single-pending mode until a completion arrives.

// File: rtl/bts_pkg.sv
package bts_pkg;

    typedef enum logic [3:0] {
        CMD_MRD = 4'b0110,
        CMD_MRL = 4'b1110,
        CMD_MRM = 4'b1100,
        CMD_MWR = 4'b0111
    } pci_cmd_e;

    function automatic pci_cmd_e pick_cmd(input logic is_wr,
                                          input logic one_beat,
                                          input logic many_lines);
        if (is_wr)           return CMD_MWR;
        else if (one_beat)   return CMD_MRD;
        else if (many_lines) return CMD_MRM;
        else                 return CMD_MRL;
    endfunction

    function automatic logic cmd_is_read(input pci_cmd_e c);
        return c != CMD_MWR;
    endfunction

endpackage

// File: rtl/bts_plan.sv
module bts_plan
    import bts_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_W    = 20,
    parameter int IDX_W     = 2,
    parameter int CNT_W     = 8,
    parameter int CLS_W     = 8,
    parameter int MAX_BEATS = 128,
    parameter int DW_W      = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  beats,
    input  logic              is_wr,
    input  logic              wide,
    input  logic [CLS_W-1:0]  cls,
    output pci_cmd_e          cmd,
    output logic              split,
    output logic [IDX_W-1:0]  idx1,
    output logic [IDX_W-1:0]  idx2,
    output logic [PAGE_W-1:0] off1,
    output logic [DW_W-1:0]   dw1,
    output logic [DW_W-1:0]   dw2
);
    localparam logic [ADDR_W-1:0] PAGE_DW = {{(ADDR_W-1){1'b0}}, 1'b1} << (PAGE_W-2);
    localparam int LW = ADDR_W - 2;

    logic [ADDR_W-1:0] abase;
    logic [DW_W-1:0]   nbeats;
    logic [DW_W-1:0]   dw_tot;
    logic [ADDR_W-1:0] offs_dw;
    logic [ADDR_W-1:0] room_dw;
    logic [LW-1:0]     first_dw;
    logic [LW-1:0]     last_dw;
    logic [LW-1:0]     line_mask;
    logic              many_lines;

    always_comb begin
        // clamp the beat count into 1..MAX_BEATS
        if (beats == '0)
            nbeats = DW_W'(1);
        else if (DW_W'(beats) > DW_W'(MAX_BEATS))
            nbeats = DW_W'(MAX_BEATS);
        else
            nbeats = DW_W'(beats);
        dw_tot = wide ? (nbeats << 1) : nbeats;

        abase   = addr & ~ADDR_W'(3);
        off1    = abase[PAGE_W-1:0];
        idx1    = abase[PAGE_W +: IDX_W];
        idx2    = idx1 + 1'b1;
        offs_dw = {{(ADDR_W-PAGE_W){1'b0}}, off1} >> 2;
        room_dw = PAGE_DW - offs_dw;
        split   = ADDR_W'(dw_tot) > room_dw;
        dw1     = split ? room_dw[DW_W-1:0] : dw_tot;
        dw2     = dw_tot - dw1;

        // cacheline span, line length a power of two in dwords
        first_dw   = LW'(abase >> 2);
        last_dw    = first_dw + LW'(dw_tot) - 1'b1;
        line_mask  = ~(LW'(cls) - 1'b1);
        many_lines = (cls != '0) && (|((first_dw ^ last_dw) & line_mask));

        cmd = pick_cmd(is_wr, nbeats == DW_W'(1), many_lines);
    end

endmodule

// File: rtl/bts_xlate.sv
module bts_xlate #(
    parameter int ADDR_W   = 32,
    parameter int PAGE_W   = 20,
    parameter int PT_DEPTH = 4,
    parameter int IDX_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pt_wr,
    input  logic [IDX_W-1:0]         pt_idx,
    input  logic [ADDR_W-PAGE_W-1:0] pt_frame,
    input  logic [IDX_W-1:0]         idx_a,
    input  logic [PAGE_W-1:0]        off_a,
    input  logic [IDX_W-1:0]         idx_b,
    output logic [ADDR_W-1:0]        pa_a,
    output logic [ADDR_W-1:0]        pa_b
);
    localparam int FRAME_W = ADDR_W - PAGE_W;

    logic [FRAME_W-1:0] tbl [PT_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PT_DEPTH; i++)
                tbl[i] <= FRAME_W'(i);
        end else if (pt_wr) begin
            tbl[pt_idx] <= pt_frame;
        end
    end

    assign pa_a = {tbl[idx_a], off_a};
    assign pa_b = {tbl[idx_b], {PAGE_W{1'b0}}};

endmodule

// File: rtl/bts_rdtrack.sv
module bts_rdtrack #(
    parameter int MULTI_LIM  = 4,
    parameter int SINGLE_LIM = 1,
    parameter int RD_W       = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            multi,
    input  logic            issue,
    input  logic            done,
    output logic [RD_W-1:0] cnt,
    output logic            can_issue
);
    logic [RD_W-1:0] limit;
    logic            dec;

    assign limit     = multi ? RD_W'(MULTI_LIM) : RD_W'(SINGLE_LIM);
    assign can_issue = cnt < limit;
    assign dec       = done && (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case ({issue, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/bts_splitter.sv
module bts_splitter
    import bts_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_W    = 20,
    parameter int PT_DEPTH  = 4,
    parameter int CNT_W     = 8,
    parameter int CLS_W     = 8,
    parameter int MAX_BEATS = 128,
    parameter int MULTI_LIM = 4,
    parameter int IDX_W     = $clog2(PT_DEPTH),
    parameter int DW_W      = $clog2(MAX_BEATS * 2) + 1,
    parameter int RD_W      = $clog2(MULTI_LIM + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [CNT_W-1:0]         req_beats,
    input  logic                     req_write,
    input  logic                     req_wide,
    input  logic [CLS_W-1:0]         cls_dwords,
    input  logic                     multi_mode,
    input  logic                     rd_done,
    input  logic                     pt_wr,
    input  logic [IDX_W-1:0]         pt_idx,
    input  logic [ADDR_W-PAGE_W-1:0] pt_frame,
    output logic                     desc_valid,
    input  logic                     desc_ready,
    output logic [3:0]               desc_cmd,
    output logic [ADDR_W-1:0]        desc_addr,
    output logic [DW_W-1:0]          desc_dwords,
    output logic                     wip,
    output logic [RD_W-1:0]          rd_outstanding
);
    pci_cmd_e          p_cmd;
    logic              p_split;
    logic [IDX_W-1:0]  p_idx1, p_idx2;
    logic [PAGE_W-1:0] p_off1;
    logic [DW_W-1:0]   p_dw1, p_dw2;
    logic [ADDR_W-1:0] p_pa1, p_pa2;

    pci_cmd_e          cmd_q;
    logic              split_q, wr_q, busy_q, phase_q;
    logic [ADDR_W-1:0] pa1_q, pa2_q;
    logic [DW_W-1:0]   dw1_q, dw2_q;

    logic accept, fire, can_rd;

    bts_plan #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
        .CLS_W(CLS_W), .MAX_BEATS(MAX_BEATS), .DW_W(DW_W)
    ) u_plan (
        .addr(req_addr), .beats(req_beats), .is_wr(req_write), .wide(req_wide),
        .cls(cls_dwords), .cmd(p_cmd), .split(p_split), .idx1(p_idx1),
        .idx2(p_idx2), .off1(p_off1), .dw1(p_dw1), .dw2(p_dw2)
    );

    bts_xlate #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PT_DEPTH(PT_DEPTH), .IDX_W(IDX_W)
    ) u_xlate (
        .clk(clk), .rst(rst), .pt_wr(pt_wr), .pt_idx(pt_idx), .pt_frame(pt_frame),
        .idx_a(p_idx1), .off_a(p_off1), .idx_b(p_idx2), .pa_a(p_pa1), .pa_b(p_pa2)
    );

    bts_rdtrack #(
        .MULTI_LIM(MULTI_LIM), .SINGLE_LIM(1), .RD_W(RD_W)
    ) u_rd (
        .clk(clk), .rst(rst), .multi(multi_mode),
        .issue(fire && cmd_is_read(cmd_q)), .done(rd_done),
        .cnt(rd_outstanding), .can_issue(can_rd)
    );

    assign req_ready   = !busy_q;
    assign accept      = req_valid && req_ready;
    assign desc_valid  = busy_q && (wr_q || can_rd);
    assign fire        = desc_valid && desc_ready;
    assign desc_cmd    = cmd_q;
    assign desc_addr   = phase_q ? pa2_q : pa1_q;
    assign desc_dwords = phase_q ? dw2_q : dw1_q;
    assign wip         = busy_q && wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            split_q <= 1'b0;
            wr_q    <= 1'b0;
            cmd_q   <= CMD_MRD;
            pa1_q   <= '0;
            pa2_q   <= '0;
            dw1_q   <= '0;
            dw2_q   <= '0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            split_q <= p_split;
            wr_q    <= req_write;
            cmd_q   <= p_cmd;
            pa1_q   <= p_pa1;
            pa2_q   <= p_pa2;
            dw1_q   <= p_dw1;
            dw2_q   <= p_dw2;
        end else if (fire) begin
            if (split_q && !phase_q)
                phase_q <= 1'b1;
            else
                busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/bts_splitter_chk.sv
module bts_splitter_chk #(
    parameter int ADDR_W    = 32,
    parameter int MAX_BEATS = 128,
    parameter int MULTI_LIM = 4,
    parameter int DW_W      = 9,
    parameter int RD_W      = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              multi_mode,
    input logic              desc_valid,
    input logic              desc_ready,
    input logic [3:0]        desc_cmd,
    input logic [ADDR_W-1:0] desc_addr,
    input logic [DW_W-1:0]   desc_dwords,
    input logic              wip,
    input logic [RD_W-1:0]   rd_outstanding
);
    p_align_r1: assert property (@(posedge clk) disable iff (rst)
        desc_valid |-> desc_addr[1:0] == 2'b00);

    p_dw_range_r2: assert property (@(posedge clk) disable iff (rst)
        desc_valid |-> (desc_dwords != '0) && (desc_dwords <= DW_W'(2 * MAX_BEATS)));

    p_wr_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        desc_valid && wip |-> desc_cmd == 4'b0111);

    p_rd_cap_r7: assert property (@(posedge clk) disable iff (rst)
        desc_valid && desc_cmd != 4'b0111 |->
            rd_outstanding < (multi_mode ? RD_W'(MULTI_LIM) : RD_W'(1)));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        rd_outstanding <= RD_W'(MULTI_LIM));

    p_wip_set_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && req_write |=> wip);

    p_stall_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !desc_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        desc_valid && !desc_ready |=>
            $stable(desc_addr) && $stable(desc_cmd) && $stable(desc_dwords));

endmodule

bind bts_splitter bts_splitter_chk #(
    .ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS), .MULTI_LIM(MULTI_LIM),
    .DW_W(DW_W), .RD_W(RD_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .multi_mode(multi_mode), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_cmd(desc_cmd), .desc_addr(desc_addr),
    .desc_dwords(desc_dwords), .wip(wip), .rd_outstanding(rd_outstanding)
);

// File: tb/bts_splitter_test.sv
module bts_splitter_test;
    localparam int PW = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_beats = '0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [7:0]  cls_dwords = 8'd16;
    logic        multi_mode = 1'b1;
    logic        rd_done = 1'b0;
    logic        pt_wr = 1'b0;
    logic [1:0]  pt_idx = '0;
    logic [11:0] pt_frame = '0;
    logic        desc_valid;
    logic        desc_ready = 1'b0;
    logic [3:0]  desc_cmd;
    logic [31:0] desc_addr;
    logic [8:0]  desc_dwords;
    logic        wip;
    logic [2:0]  rd_outstanding;

    bts_splitter uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_beats(req_beats), .req_write(req_write),
        .req_wide(req_wide), .cls_dwords(cls_dwords), .multi_mode(multi_mode),
        .rd_done(rd_done), .pt_wr(pt_wr), .pt_idx(pt_idx), .pt_frame(pt_frame),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_cmd(desc_cmd),
        .desc_addr(desc_addr), .desc_dwords(desc_dwords), .wip(wip),
        .rd_outstanding(rd_outstanding)
    );

    always #10 clk = ~clk;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [11:0] pt_model [4];
    logic [44:0] exp_q [$];
    string       tag_q [$];
    int          tb_out = 0;
    bit          auto_done = 1'b1;
    bit          manual_req = 1'b0;
    bit          ready_hold = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    int          cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic longint xl(input longint a);
        return (longint'(pt_model[(a >> PW) % 4]) << PW) | (a & ((64'd1 << PW) - 1));
    endfunction

    task automatic push(input logic [3:0] c, input longint a, input longint d, input string t);
        exp_q.push_back({c, a[31:0], d[8:0]});
        tag_q.push_back(t);
    endtask

    task automatic send(input longint a, input int cnt, input bit wr, input bit wd, input string t);
        longint beats, bytes, start, pend, ln;
        logic [3:0] c;
        bit acc;
        beats = (cnt == 0) ? 1 : (cnt > 128 ? 128 : cnt);
        bytes = beats * (wd ? 8 : 4);
        start = a & 64'hFFFF_FFFC;
        pend  = ((start >> PW) + 1) << PW;
        ln    = longint'(cls_dwords) * 4;
        if (wr) c = 4'b0111;
        else if (beats == 1) c = 4'b0110;
        else if (ln != 0 && (start / ln) != ((start + bytes - 1) / ln)) c = 4'b1100;
        else c = 4'b1110;
        if (start + bytes > pend) begin
            push(c, xl(start), (pend - start) / 4, t);
            push(c, xl(pend & 64'hFFFF_FFFF), (bytes - (pend - start)) / 4, t);
        end else begin
            push(c, xl(start), bytes / 4, t);
        end
        @(negedge clk);
        req_addr = a[31:0]; req_beats = cnt[7:0]; req_write = wr; req_wide = wd;
        req_valid = 1'b1;
        do begin
            #5 acc = req_ready;
            @(negedge clk);
        end while (!acc);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && (exp_q.size() != 0 || desc_valid); i++)
            @(negedge clk);
        #5 chk(exp_q.size() == 0, "R3 drain", exp_q.size(), 0);
    endtask

    task automatic set_pt(input int i, input logic [11:0] f);
        @(negedge clk);
        pt_wr = 1'b1; pt_idx = i[1:0]; pt_frame = f;
        @(negedge clk);
        pt_wr = 1'b0;
        pt_model[i] = f;
    endtask

    task automatic pulse_done();
        @(posedge clk);
        manual_req = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // descriptor-side ready pattern and completion generator
    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        desc_ready = ready_hold ? 1'b0 : (lfsr[0] | lfsr[1]);
        if (manual_req) begin
            rd_done = 1'b1;
            manual_req = 1'b0;
        end else begin
            rd_done = auto_done && (tb_out > 0) && !rd_done && (cyc % 3 == 0);
        end
    end

    // monitor: pops the scoreboard on every accepted descriptor
    always begin
        @(negedge clk);
        #5;
        if (!rst) begin
            logic [44:0] e;
            string t;
            bit rd_fire;
            chk(rd_outstanding == tb_out[2:0], "R7 count", rd_outstanding, tb_out);
            rd_fire = desc_valid && desc_ready && desc_cmd != 4'b0111;
            if (desc_valid && desc_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected descriptor", desc_addr, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(desc_cmd == e[44:41], {"R6 cmd ", t}, desc_cmd, e[44:41]);
                    chk(desc_addr == e[40:9], {"R4 addr ", t}, desc_addr, e[40:9]);
                    chk(desc_dwords == e[8:0], {"R2 dwords ", t}, desc_dwords, e[8:0]);
                end
                if (rd_fire)
                    chk(tb_out < (multi_mode ? 4 : 1), "R7 cap", tb_out, multi_mode ? 4 : 1);
            end
            if (rd_done && tb_out > 0) tb_out--;
            if (rd_fire) tb_out++;
        end
    end

    initial begin
        #(20 * 190000);
        chk(1'b0, "watchdog", 0, 1);
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) pt_model[i] = 12'(i);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #5;
        chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
        chk(desc_valid == 1'b0, "R9 reset valid", desc_valid, 0);
        chk(wip == 1'b0, "R8 reset wip", wip, 0);
        chk(rd_outstanding == 3'd0, "R7 reset count", rd_outstanding, 0);

        // R4: reset table, frame = page index
        send(64'h0020_0104, 1, 1'b1, 1'b0, "R4 reset table");
        drain();

        set_pt(0, 12'hA00);
        set_pt(1, 12'hB11);
        set_pt(2, 12'hC22);
        set_pt(3, 12'hD33);

        // R1 / R2 / R6 writes
        send(64'h0000_1006, 1, 1'b1, 1'b0, "R1 unaligned write");
        send(64'h0000_2000, 200, 1'b1, 1'b0, "R2 clamp 200");
        send(64'h0000_3000, 0, 1'b1, 1'b0, "R2 zero count");
        send(64'h0000_4000, 128, 1'b1, 1'b1, "R2 wide 128");
        // R5 / R6 reads, line = 16 dwords
        send(64'h0000_0100, 1, 1'b0, 1'b0, "R6 single read");
        send(64'h0000_0040, 4, 1'b0, 1'b0, "R6 read line");
        send(64'h0000_0030, 16, 1'b0, 1'b0, "R5 multi line");
        send(64'h0000_0038, 2, 1'b0, 1'b1, "R5 wide crossing");
        drain();
        cls_dwords = 8'd0;
        send(64'h0000_0000, 64, 1'b0, 1'b0, "R5 no cacheline");
        drain();
        cls_dwords = 8'd8;
        send(64'h0000_0020, 8, 1'b0, 1'b0, "R6 exactly one line");
        // R3 splits
        send(64'h000F_FFF0, 8, 1'b0, 1'b0, "R3 read split");
        send(64'h003F_FF00, 128, 1'b1, 1'b1, "R3 wrap split");
        send(64'h001F_FFF0, 4, 1'b0, 1'b0, "R3 ends on boundary");
        drain();

        // R7 single pending
        for (int i = 0; i < 200 && tb_out != 0; i++) @(negedge clk);
        auto_done = 1'b0;
        multi_mode = 1'b0;
        send(64'h0000_0500, 1, 1'b0, 1'b0, "R7 single A");
        send(64'h0000_0600, 1, 1'b0, 1'b0, "R7 single B");
        repeat (8) @(negedge clk);
        #5;
        chk(desc_valid == 1'b0, "R7 second read held", desc_valid, 0);
        chk(exp_q.size() == 1, "R7 one issued", exp_q.size(), 1);
        pulse_done();
        drain();
        pulse_done();

        // R7 multi pending
        multi_mode = 1'b1;
        for (int i = 0; i < 5; i++)
            send(64'h0000_0700 + 64'(i * 64), 1, 1'b0, 1'b0, "R7 multi");
        repeat (8) @(negedge clk);
        #5;
        chk(rd_outstanding == 3'd4, "R7 four outstanding", rd_outstanding, 4);
        chk(exp_q.size() == 1, "R7 fifth held", exp_q.size(), 1);
        auto_done = 1'b1;
        drain();

        // R8 / R9 with stalled output, split write
        @(posedge clk);
        ready_hold = 1'b1;
        send(64'h000F_FFF8, 4, 1'b1, 1'b0, "R8 split write");
        #5;
        chk(wip == 1'b1, "R8 wip after accept", wip, 1);
        chk(req_ready == 1'b0, "R9 stall", req_ready, 0);
        repeat (3) @(negedge clk);
        #5;
        chk(desc_valid == 1'b1, "R9 offered", desc_valid, 1);
        chk(desc_addr == 32'hA00F_FFF8, "R9 held addr", desc_addr, 32'hA00F_FFF8);
        @(posedge clk);
        ready_hold = 1'b0;
        drain();
        chk(wip == 1'b0, "R8 wip cleared", wip, 0);
        chk(req_ready == 1'b1, "R9 ready again", req_ready, 1);

        report();
        $finish;
    end

endmodule